// File: doc/BRIEF.md
# Dual-axis current regulator with decoupling feed-forward

This block closes the inner current loops of a field-oriented motor drive. It holds two discrete proportional-integral regulators, one for the direct-axis current and one for the quadrature-axis current. It adds to each regulator a model-based voltage term that cancels the resistive drop, the inductive drop and the cross-axis coupling. The quadrature axis also gets a back-EMF term. Each voltage command is clamped to a programmable symmetric limit.

A sample strobe starts each update; in a drive this strobe runs at the loop rate, typically 8 kHz. On the strobe the block captures the references, the measured currents, the electrical speed and the per-sample current slope estimates. Both axes then work through a fixed three-phase sequence. The sequence ends with new commands and a one-cycle done pulse. The gains, the integrator limit, the voltage limit and the motor constants are live inputs that are held steady while an update runs. All values are signed fixed point with `FRAC` fraction bits. Every product is floor-shifted right by `FRAC` on its own.

Top module: `dq_current_reg`

## Requirements
- R1: The error of each axis is its reference minus its measured current. The proportional part is floor((kp*e)/2^FRAC).
- R2: On every accepted update, each integrator adds floor((ki*e)/2^FRAC). The updated integrator value is part of that same update's command.
- R3: After each accumulation the integrator is clamped to the range [-int_lim, +int_lim].
- R4: The previous update may have left the unclamped sum above +v_lim with a positive error now, or below -v_lim with a negative error now. In that case the integrator of that axis keeps its value for this update.
- R5: The d feed-forward is fl(R*id) + fl(L*did) - fl(L*fl(iq*w)), where fl(x) = floor(x/2^FRAC). It uses the measured currents and the captured speed w.
- R6: The q feed-forward is fl(R*iq) + fl(L*diq) + fl(L*fl(id*w)) + fl(psi*w).
- R7: Each command is clamp(P + I + FF, -v_lim, +v_lim).
- R8: Let the strobe be sampled at clock edge E0. The commands change and done goes high at edge E0+2. Done lasts exactly one cycle, and the commands do not change at any other time.
- R9: A strobe that arrives while an update is in progress or while done is high is ignored. It produces no further done pulse and no extra integrator step.
- R10: An active-low reset sets both integrators, both commands and done to zero, and clears the saturation history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | Starts one regulator update |
| id_ref | input | W | d-axis current reference |
| iq_ref | input | W | q-axis current reference |
| id_meas | input | W | Measured d-axis current |
| iq_meas | input | W | Measured q-axis current |
| omega_e | input | W | Electrical speed |
| did_est | input | W | d-current change per sample |
| diq_est | input | W | q-current change per sample |
| kp | input | W | Proportional gain |
| ki | input | W | Integral gain per sample |
| int_lim | input | W | Integrator magnitude limit (non-negative) |
| v_lim | input | W | Command magnitude limit (non-negative) |
| res_s | input | W | Stator resistance |
| ind_s | input | W | Stator inductance |
| flux_pm | input | W | Permanent-magnet flux linkage |
| vd_cmd | output | W | d-axis voltage command |
| vq_cmd | output | W | q-axis voltage command |
| upd_done | output | 1 | One-cycle pulse when the commands are updated |

## Verification
The bench builds the block with W=10 and FRAC=4. At that size the whole signed range of the error fits in a short sweep, and every term can be computed exactly with integer floor division in the bench. A gain of 16 stands for unity, so it is easy to steer the integrator into its clamp, the output into saturation and the feed-forward products into negative floors. The narrow word also makes the anti-windup hold show up within a handful of updates. A wrong hold condition therefore diverges from the expected command almost at once.

// File: rtl/dqr_pkg.sv
package dqr_pkg;
  localparam int ACC_W = 48;
  typedef logic signed [ACC_W-1:0] acc_t;

  // fixed-point product, floor-shifted by frac
  function automatic acc_t mulq(acc_t a, acc_t b, int frac);
    logic signed [2*ACC_W-1:0] ax, bx, pr;
    ax = a;
    bx = b;
    pr = ax * bx;
    return acc_t'(pr >>> frac);
  endfunction

  // symmetric clamp, lim assumed non-negative
  function automatic acc_t clampsym(acc_t x, acc_t lim);
    if (x > lim) return lim;
    if (x < -lim) return -lim;
    return x;
  endfunction
endpackage

// File: rtl/dqr_seq.sv
module dqr_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic capture,
  output logic step1,
  output logic step2,
  output logic done
);
  logic [2:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ph <= '0;
    else if (ph == 3'b0) ph <= strobe ? 3'b001 : 3'b000;
    else                 ph <= ph << 1;
  end

  assign capture = strobe && (ph == 3'b0);
  assign step1   = ph[0];
  assign step2   = ph[1];
  assign done    = ph[2];
endmodule

// File: rtl/dqr_ff.sv
module dqr_ff
  import dqr_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic signed [W-1:0] r_s,
  input  logic signed [W-1:0] l_s,
  input  logic signed [W-1:0] psi,
  input  logic signed [W-1:0] id,
  input  logic signed [W-1:0] iq,
  input  logic signed [W-1:0] did,
  input  logic signed [W-1:0] diq,
  input  logic signed [W-1:0] w,
  output acc_t                ff_d,
  output acc_t                ff_q
);
  acc_t rx, lx, px, idx, iqx, didx, diqx, wx;
  acc_t iq_w, id_w;

  always_comb begin
    rx   = acc_t'(r_s);
    lx   = acc_t'(l_s);
    px   = acc_t'(psi);
    idx  = acc_t'(id);
    iqx  = acc_t'(iq);
    didx = acc_t'(did);
    diqx = acc_t'(diq);
    wx   = acc_t'(w);
    iq_w = mulq(iqx, wx, FRAC);
    id_w = mulq(idx, wx, FRAC);
    ff_d = mulq(rx, idx, FRAC) + mulq(lx, didx, FRAC) - mulq(lx, iq_w, FRAC);
    ff_q = mulq(rx, iqx, FRAC) + mulq(lx, diqx, FRAC) + mulq(lx, id_w, FRAC)
         + mulq(px, wx, FRAC);
  end
endmodule

// File: rtl/dqr_pi_axis.sv
module dqr_pi_axis
  import dqr_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step1,
  input  logic                step2,
  input  logic signed [W-1:0] ref_i,
  input  logic signed [W-1:0] meas_i,
  input  logic signed [W-1:0] kp,
  input  logic signed [W-1:0] ki,
  input  logic signed [W-1:0] int_lim,
  input  logic signed [W-1:0] v_lim,
  input  acc_t                ff,
  output logic signed [W-1:0] v_out,
  output logic signed [W-1:0] integ,
  output logic                hold
);
  acc_t err, i_next, psum, v_lim_x;
  logic sat_hi, sat_lo;

  assign v_lim_x = acc_t'(v_lim);

  always_comb begin
    err    = acc_t'(ref_i) - acc_t'(meas_i);
    hold   = (sat_hi && err > 0) || (sat_lo && err < 0);
    i_next = hold ? acc_t'(integ)
                  : clampsym(acc_t'(integ) + mulq(acc_t'(ki), err, FRAC), acc_t'(int_lim));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ  <= '0;
      psum   <= '0;
      v_out  <= '0;
      sat_hi <= 1'b0;
      sat_lo <= 1'b0;
    end else begin
      if (step1) begin
        integ <= W'(i_next);
        psum  <= mulq(acc_t'(kp), err, FRAC) + i_next + ff;
      end
      if (step2) begin
        v_out  <= W'(clampsym(psum, v_lim_x));
        sat_hi <= psum > v_lim_x;
        sat_lo <= psum < -v_lim_x;
      end
    end
  end
endmodule

// File: rtl/dq_current_reg.sv
module dq_current_reg
  import dqr_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_stb,
  input  logic signed [W-1:0] id_ref,
  input  logic signed [W-1:0] iq_ref,
  input  logic signed [W-1:0] id_meas,
  input  logic signed [W-1:0] iq_meas,
  input  logic signed [W-1:0] omega_e,
  input  logic signed [W-1:0] did_est,
  input  logic signed [W-1:0] diq_est,
  input  logic signed [W-1:0] kp,
  input  logic signed [W-1:0] ki,
  input  logic signed [W-1:0] int_lim,
  input  logic signed [W-1:0] v_lim,
  input  logic signed [W-1:0] res_s,
  input  logic signed [W-1:0] ind_s,
  input  logic signed [W-1:0] flux_pm,
  output logic signed [W-1:0] vd_cmd,
  output logic signed [W-1:0] vq_cmd,
  output logic                upd_done
);
  localparam int NAX = 2;

  logic capture, step1, step2;
  logic signed [W-1:0] ref_c [NAX];
  logic signed [W-1:0] meas_c[NAX];
  logic signed [W-1:0] w_c, did_c, diq_c;
  acc_t                ff_w  [NAX];
  logic signed [W-1:0] v_w   [NAX];
  logic signed [W-1:0] integ_w[NAX];
  logic                hold_w[NAX];

  // named internal events for the checker
  logic signed [W-1:0] integ_d, integ_q;
  logic                hold_d, hold_q;

  dqr_seq seq_i (
    .clk(clk), .rst_n(rst_n), .strobe(sample_stb),
    .capture(capture), .step1(step1), .step2(step2), .done(upd_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < NAX; a++) begin
        ref_c[a]  <= '0;
        meas_c[a] <= '0;
      end
      w_c   <= '0;
      did_c <= '0;
      diq_c <= '0;
    end else if (capture) begin
      ref_c[0]  <= id_ref;
      ref_c[1]  <= iq_ref;
      meas_c[0] <= id_meas;
      meas_c[1] <= iq_meas;
      w_c       <= omega_e;
      did_c     <= did_est;
      diq_c     <= diq_est;
    end
  end

  dqr_ff #(.W(W), .FRAC(FRAC)) ff_i (
    .r_s(res_s), .l_s(ind_s), .psi(flux_pm),
    .id(meas_c[0]), .iq(meas_c[1]), .did(did_c), .diq(diq_c), .w(w_c),
    .ff_d(ff_w[0]), .ff_q(ff_w[1])
  );

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    dqr_pi_axis #(.W(W), .FRAC(FRAC)) pi_i (
      .clk(clk), .rst_n(rst_n), .step1(step1), .step2(step2),
      .ref_i(ref_c[g]), .meas_i(meas_c[g]), .kp(kp), .ki(ki),
      .int_lim(int_lim), .v_lim(v_lim), .ff(ff_w[g]),
      .v_out(v_w[g]), .integ(integ_w[g]), .hold(hold_w[g])
    );
  end

  assign vd_cmd  = v_w[0];
  assign vq_cmd  = v_w[1];
  assign integ_d = integ_w[0];
  assign integ_q = integ_w[1];
  assign hold_d  = hold_w[0];
  assign hold_q  = hold_w[1];
endmodule

// File: rtl/dqr_chk.sv
module dqr_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                done,
  input logic                step1,
  input logic signed [W-1:0] vd,
  input logic signed [W-1:0] vq,
  input logic signed [W-1:0] v_lim,
  input logic signed [W-1:0] int_lim,
  input logic signed [W-1:0] integ_d,
  input logic signed [W-1:0] integ_q,
  input logic                hold_d,
  input logic                hold_q
);
  logic signed [W:0] vl, il, vdx, vqx, idx, iqx;
  assign vl  = v_lim;
  assign il  = int_lim;
  assign vdx = vd;
  assign vqx = vq;
  assign idx = integ_d;
  assign iqx = integ_q;

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(vd) && $stable(vq)));
  // R7
  cmd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vdx <= vl && vdx >= -vl && vqx <= vl && vqx >= -vl));
  // R3
  integ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step1 |=> (idx <= il && idx >= -il && iqx <= il && iqx >= -il));
  // R4
  hold_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step1 && hold_d) |=> $stable(integ_d));
  // R4
  hold_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step1 && hold_q) |=> $stable(integ_q));
endmodule

bind dq_current_reg dqr_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .done(upd_done), .step1(step1),
  .vd(vd_cmd), .vq(vq_cmd), .v_lim(v_lim), .int_lim(int_lim),
  .integ_d(integ_d), .integ_q(integ_q), .hold_d(hold_d), .hold_q(hold_q)
);

// File: tb/dq_current_reg_tb_top.sv
module dq_current_reg_tb_top;
  localparam int W = 10;
  localparam int F = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, stb;
  logic signed [W-1:0] idr, iqr, idm, iqm, om, did, diq, kp, ki, ilim, vlim, rs, ls, psi;
  logic signed [W-1:0] vd, vq;
  logic done;

  dq_current_reg #(.W(W), .FRAC(F)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_stb(stb),
    .id_ref(idr), .iq_ref(iqr), .id_meas(idm), .iq_meas(iqm),
    .omega_e(om), .did_est(did), .diq_est(diq), .kp(kp), .ki(ki),
    .int_lim(ilim), .v_lim(vlim), .res_s(rs), .ind_s(ls), .flux_pm(psi),
    .vd_cmd(vd), .vq_cmd(vq), .upd_done(done)
  );

  int checks = 0, fails = 0;
  longint mi[2];
  bit shi[2], slo[2];
  longint ev[2];

  function automatic longint fl(longint x);
    longint d, r;
    d = longint'(1) << F;
    r = x % d;
    if (r < 0) r += d;
    return (x - r) / d;
  endfunction

  function automatic longint clp(longint x, longint l);
    return (x > l) ? l : ((x < -l) ? -l : x);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int a = 0; a < 2; a++) begin mi[a] = 0; shi[a] = 0; slo[a] = 0; end
  endtask

  task automatic model_step();
    longint rf[2], ms[2], ff[2], e, u, l, r, w, p;
    rf[0] = idr; rf[1] = iqr; ms[0] = idm; ms[1] = iqm;
    l = ls; r = rs; w = om; p = psi;
    ff[0] = fl(r * ms[0]) + fl(l * longint'(did)) - fl(l * fl(ms[1] * w));
    ff[1] = fl(r * ms[1]) + fl(l * longint'(diq)) + fl(l * fl(ms[0] * w)) + fl(p * w);
    for (int a = 0; a < 2; a++) begin
      e = rf[a] - ms[a];
      if (!((shi[a] && e > 0) || (slo[a] && e < 0)))
        mi[a] = clp(mi[a] + fl(longint'(ki) * e), longint'(ilim));
      u = fl(longint'(kp) * e) + mi[a] + ff[a];
      ev[a] = clp(u, longint'(vlim));
      shi[a] = u > longint'(vlim);
      slo[a] = u < -longint'(vlim);
    end
  endtask

  // one update; done timing is R8
  task automatic update(string tag_d, string tag_q);
    @(negedge clk) stb = 1'b1;
    @(negedge clk) stb = 1'b0;
    chk("R8 done early", done, 0);
    @(negedge clk);
    chk("R8 done early", done, 0);
    @(negedge clk);
    chk("R8 done edge", done, 1);
    model_step();
    chk(tag_d, vd, ev[0]);
    chk(tag_q, vq, ev[1]);
    @(negedge clk);
    chk("R8 done width", done, 0);
  endtask

  task automatic zero_all();
    idr = 0; iqr = 0; idm = 0; iqm = 0; om = 0; did = 0; diq = 0;
    kp = 0; ki = 0; ilim = 0; vlim = 0; rs = 0; ls = 0; psi = 0;
  endtask

  bit finished = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int dones;
    rst_n = 1'b0; stb = 1'b0; zero_all();
    model_reset();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 vd", vd, 0); chk("R10 vq", vq, 0); chk("R10 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 proportional sweep
    kp = 24; vlim = 511;
    for (int r = -240; r <= 240; r += 16) begin
      idr = r; idm = (r * 5) % 37; iqr = -r; iqm = 7;
      update("R1 vd", "R1 vq");
    end

    // R2 / R3 integral accumulation and clamp
    kp = 0; ki = 16; ilim = 100; idr = 30; idm = 0; iqr = -45; iqm = 0;
    for (int k = 0; k < 6; k++) update("R2 R3 vd", "R2 R3 vq");
    idr = -20; iqr = 20;
    for (int k = 0; k < 2; k++) update("R2 vd", "R2 vq");

    // R10 mid-run reset clears integrators
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    model_reset();
    chk("R10 vd after reset", vd, 0);
    idr = 0; iqr = 0;
    update("R10 vd", "R10 vq");

    // R4 anti-windup
    kp = 16; ki = 16; ilim = 400; vlim = 60; idr = 50; iqr = -50;
    for (int k = 0; k < 5; k++) update("R4 vd", "R4 vq");
    idr = -10; iqr = 10;
    for (int k = 0; k < 3; k++) update("R4 vd", "R4 vq");

    // R5 / R6 feed-forward sweep
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    model_reset(); zero_all();
    vlim = 511; rs = 8; ls = 12; psi = 12; idm = 40; iqm = -30;
    for (int w = -160; w <= 160; w += 20) begin
      om = w; did = w / 4; diq = -(w / 5);
      update("R5 vd", "R6 vq");
    end
    idm = -37; iqm = 53;
    for (int w = -150; w <= 150; w += 50) begin
      om = w; did = -w / 3; diq = 11;
      update("R5 vd", "R6 vq");
    end

    // R7 output clamp
    zero_all(); kp = 32; vlim = 100;
    for (int e = -150; e <= 150; e += 10) begin
      idr = e; iqr = -e;
      update("R7 vd", "R7 vq");
    end
    vlim = 0; idr = 90; iqr = -90;
    update("R7 vd zero lim", "R7 vq zero lim");

    // R9 strobe during busy is ignored
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    model_reset(); zero_all();
    ki = 16; ilim = 300; vlim = 511; idr = 10; iqr = 5;
    @(negedge clk) stb = 1'b1;
    dones = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      stb = (c < 3);
      if (done) dones++;
    end
    chk("R9 done count", dones, 1);
    model_step();
    chk("R9 vd", vd, ev[0]);
    chk("R9 vq", vq, ev[1]);
    update("R9 vd next", "R9 vq next");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule